// File: doc/BRIEF.md
# SETUP Request Capture Queue

This block sits next to a USB protocol engine. The engine reports decoded tokens, received data bytes and the end of each data packet as an abstract strobe stream. When a SETUP token arrives, the block arms itself, empties any bytes left over from an earlier request and records the endpoint number. The data packet that follows is written byte by byte into a small queue that holds the eight request bytes and the two CRC bytes. When that packet ends, the block always asks the engine to send a handshake ACK. It never stalls or refuses a control request.

A processor reads the request one byte at a time. The oldest byte is always visible on a data output, and a pop strobe moves the queue to the next byte. Status outputs show whether unread bytes remain, the direction bit of the request, the endpoint that received the last SETUP, and an event flag. The event flag also drives the interrupt line. It is set when a complete ten-byte request has been stored and stays set until the processor writes a clear strobe. A soft-reset strobe returns the whole unit to its idle state.

A SETUP token is not always followed by data. Any other token that arrives before the data packet ends the capture. Bytes that arrive after that are not stored and are not acknowledged.

Top module: `setup_capture`

## Requirements
- R1: After `rst_n` is released: `cpu_have`, `cpu_is_in`, `cpu_event`, `irq` and `ack_stb` are 0, and `cpu_ep` is 0.
- R2: A token strobe with `tok_setup`=1 and endpoint E does three things, all visible in the next cycle. `cpu_ep` becomes E. Unread bytes are discarded, so `cpu_have` becomes 0. `cpu_is_in` becomes 0.
- R3: Bytes strobed on `rx_stb` after a SETUP token are queued in arrival order. `cpu_data` shows the oldest unread byte whenever `cpu_have`=1. Each `cpu_pop` removes one byte. Only the first 10 bytes of a packet are stored, and the rest are dropped.
- R4: `cpu_is_in` takes bit 7 of the first data byte after a SETUP token, visible in the cycle after that byte.
- R5: `rx_end` while a SETUP capture is armed makes `ack_stb` high for exactly one cycle, the cycle after `rx_end`. This happens whatever the byte count. Each SETUP gets at most one ACK.
- R6: When the packet ending on `rx_end` held exactly 10 bytes, `cpu_event` and `irq` become 1 in the next cycle. Any other length leaves them unchanged.
- R7: `cpu_irq_clr` clears `cpu_event` and `irq` in the next cycle. When a completion happens in the same cycle, the set wins.
- R8: `cpu_pop` while the queue is empty is ignored. `cpu_have` stays 0, and later bytes are queued normally.
- R9: `cpu_reset` has priority over all other inputs. One cycle later it has emptied the queue, cleared `cpu_ep`, `cpu_is_in`, `cpu_event` and `irq`, and cancelled any armed capture, so a following `rx_end` gives no ACK.
- R10: A token with `tok_setup`=0 cancels an armed capture and does not touch the queue. Later bytes are not stored, and a later `rx_end` gives no ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_stb | input | 1 | A token was decoded this cycle |
| tok_setup | input | 1 | The token is a SETUP token |
| tok_ep | input | EP_W | Endpoint number carried by the token |
| rx_stb | input | 1 | A data byte was received this cycle |
| rx_byte | input | 8 | Received data byte |
| rx_end | input | 1 | The current data packet ended (not together with `rx_stb`) |
| ack_stb | output | 1 | One-cycle request to send a handshake ACK |
| cpu_data | output | 8 | Oldest unread request byte |
| cpu_have | output | 1 | The queue holds unread bytes |
| cpu_is_in | output | 1 | Direction bit of the current request |
| cpu_ep | output | EP_W | Endpoint that received the last SETUP token |
| cpu_event | output | 1 | A complete request has been stored |
| irq | output | 1 | Interrupt, high while `cpu_event` is set |
| cpu_pop | input | 1 | Advance the queue by one byte |
| cpu_irq_clr | input | 1 | Clear the event flag and the interrupt |
| cpu_reset | input | 1 | Soft reset of the whole unit |

## Verification
Random transactions combine SETUP packets of 0 to 12 bytes, non-SETUP tokens followed by data, clear strobes and occasional soft resets. Pops land during and between packets. The varying packet lengths separate the exact-ten-byte completion from short and long packets, which are still acknowledged. The non-SETUP traffic shows that only armed data is stored. Directed sequences cover a pop on an empty queue, a clear that collides with a completion, a soft reset in the middle of a capture, and a SETUP token that arrives while old bytes are still unread.

// File: rtl/setup_cap_pkg.sv
package setup_cap_pkg;
  localparam int unsigned REQ_BYTES = 8;
  localparam int unsigned CRC_BYTES = 2;
  localparam int unsigned PKT_BYTES = REQ_BYTES + CRC_BYTES;

  typedef enum logic {
    CAP_IDLE  = 1'b0,
    CAP_ARMED = 1'b1
  } cap_state_e;
endpackage

// File: rtl/setup_cap_fifo.sv
module setup_cap_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 10,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign do_pop  = pop && (cnt_q != '0) && !flush;
  assign do_push = push && !flush && ((cnt_q != CNT_W'(DEPTH)) || do_pop);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= '0;
      else if (slot_we) mem_q[g] <= din;
    end
  end

  assign dout  = mem_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/setup_cap_seq.sv
module setup_cap_seq
  import setup_cap_pkg::*;
#(
  parameter int unsigned PKT = 10,
  localparam int unsigned BC_W = $clog2(PKT + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       tok_stb,
  input  logic       tok_setup,
  input  logic       rx_stb,
  input  logic       rx_end,
  output logic       flush,
  output logic       push,
  output logic       first_byte,
  output logic       complete,
  output logic       ack_stb
);
  cap_state_e      st_q, st_d;
  logic [BC_W-1:0] bc_q, bc_d;
  logic            ack_q, ack_d;
  logic            armed, byte_ok, end_ok, setup_tok;

  assign armed     = (st_q == CAP_ARMED);
  assign setup_tok = tok_stb && tok_setup;
  assign byte_ok   = !soft_rst && !tok_stb && rx_stb && armed;
  assign end_ok    = !soft_rst && !tok_stb && !rx_stb && rx_end && armed;

  assign flush      = soft_rst || setup_tok;
  assign push       = byte_ok && (bc_q < BC_W'(PKT));
  assign first_byte = byte_ok && (bc_q == '0);
  assign complete   = end_ok && (bc_q == BC_W'(PKT));

  always_comb begin
    st_d  = st_q;
    bc_d  = bc_q;
    ack_d = end_ok;
    if (soft_rst) begin
      st_d = CAP_IDLE;
      bc_d = '0;
    end else if (tok_stb) begin
      st_d = setup_tok ? CAP_ARMED : CAP_IDLE;
      bc_d = '0;
    end else if (byte_ok) begin
      if (bc_q != BC_W'(PKT + 1)) bc_d = bc_q + 1'b1;
    end else if (end_ok) begin
      st_d = CAP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CAP_IDLE;
      bc_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bc_q  <= bc_d;
      ack_q <= ack_d;
    end
  end

  assign ack_stb = ack_q;
endmodule

// File: rtl/setup_cap_status.sv
module setup_cap_status #(
  parameter int unsigned EP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            setup_tok,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            first_byte,
  input  logic            dir_bit,
  input  logic            complete,
  input  logic            evt_clr,
  output logic [EP_W-1:0] ep,
  output logic            is_in,
  output logic            evt
);
  logic [EP_W-1:0] ep_q, ep_d;
  logic            in_q, in_d, evt_q, evt_d;
  logic            ep_en, in_en;

  assign ep_en = soft_rst || setup_tok;
  assign in_en = soft_rst || setup_tok || first_byte;

  always_comb begin
    ep_d  = soft_rst ? '0 : tok_ep;
    in_d  = (soft_rst || setup_tok) ? 1'b0 : dir_bit;
    if (soft_rst)      evt_d = 1'b0;
    else if (complete) evt_d = 1'b1;
    else if (evt_clr)  evt_d = 1'b0;
    else               evt_d = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_q  <= '0;
      in_q  <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      if (ep_en) ep_q <= ep_d;
      if (in_en) in_q <= in_d;
      evt_q <= evt_d;
    end
  end

  assign ep    = ep_q;
  assign is_in = in_q;
  assign evt   = evt_q;
endmodule

// File: rtl/setup_capture.sv
module setup_capture
  import setup_cap_pkg::*;
#(
  parameter int unsigned EP_W  = 4,
  parameter int unsigned BYTES = PKT_BYTES,
  localparam int unsigned CNT_W = $clog2(BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_stb,
  input  logic            tok_setup,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            rx_stb,
  input  logic [7:0]      rx_byte,
  input  logic            rx_end,
  output logic            ack_stb,
  output logic [7:0]      cpu_data,
  output logic            cpu_have,
  output logic            cpu_is_in,
  output logic [EP_W-1:0] cpu_ep,
  output logic            cpu_event,
  output logic            irq,
  input  logic            cpu_pop,
  input  logic            cpu_irq_clr,
  input  logic            cpu_reset
);
  logic             flush, push, first_byte, complete, evt;
  logic [CNT_W-1:0] fill_cnt;

  setup_cap_seq #(.PKT(BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (cpu_reset),
    .tok_stb    (tok_stb),
    .tok_setup  (tok_setup),
    .rx_stb     (rx_stb),
    .rx_end     (rx_end),
    .flush      (flush),
    .push       (push),
    .first_byte (first_byte),
    .complete   (complete),
    .ack_stb    (ack_stb)
  );

  setup_cap_fifo #(.WIDTH(8), .DEPTH(BYTES)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .din   (rx_byte),
    .pop   (cpu_pop),
    .dout  (cpu_data),
    .count (fill_cnt)
  );

  setup_cap_status #(.EP_W(EP_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (cpu_reset),
    .setup_tok  (tok_stb && tok_setup),
    .tok_ep     (tok_ep),
    .first_byte (first_byte),
    .dir_bit    (rx_byte[7]),
    .complete   (complete),
    .evt_clr    (cpu_irq_clr),
    .ep         (cpu_ep),
    .is_in      (cpu_is_in),
    .evt        (evt)
  );

  assign cpu_have  = (fill_cnt != '0);
  assign cpu_event = evt;
  assign irq       = evt;
endmodule

// File: rtl/setup_cap_checker.sv
module setup_cap_checker #(
  parameter int unsigned EP_W  = 4,
  parameter int unsigned BYTES = 10,
  localparam int unsigned CNT_W = $clog2(BYTES + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tok_stb,
  input logic            tok_setup,
  input logic [EP_W-1:0] tok_ep,
  input logic            rx_end,
  input logic            ack_stb,
  input logic            cpu_have,
  input logic [EP_W-1:0] cpu_ep,
  input logic            cpu_event,
  input logic            irq,
  input logic            cpu_irq_clr,
  input logic            cpu_reset,
  input logic [CNT_W-1:0] fill_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(BYTES)); // R3

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> !ack_stb); // R5

  AST_ACK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> $past(rx_end)); // R5

  AST_SETUP_EP: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_stb && tok_setup && !cpu_reset) |=> (cpu_ep == $past(tok_ep)) && !cpu_have); // R2

  AST_EVENT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_event) |-> $past(rx_end)); // R6

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq_clr && !rx_end) |=> !irq); // R7

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |=> !cpu_have && !cpu_event && !irq && (cpu_ep == '0)); // R9
endmodule

bind setup_capture setup_cap_checker #(.EP_W(EP_W), .BYTES(BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tok_stb     (tok_stb),
  .tok_setup   (tok_setup),
  .tok_ep      (tok_ep),
  .rx_end      (rx_end),
  .ack_stb     (ack_stb),
  .cpu_have    (cpu_have),
  .cpu_ep      (cpu_ep),
  .cpu_event   (cpu_event),
  .irq         (irq),
  .cpu_irq_clr (cpu_irq_clr),
  .cpu_reset   (cpu_reset),
  .fill_cnt    (fill_cnt)
);

// File: tb/setup_capture_bench.sv
`timescale 1ns/1ps
module setup_capture_bench;
  localparam int EP_W = 4;
  localparam int NB   = 10;

  logic            clk;
  logic            rst_n;
  logic            tok_stb, tok_setup, rx_stb, rx_end;
  logic [EP_W-1:0] tok_ep;
  logic [7:0]      rx_byte;
  logic            ack_stb, cpu_have, cpu_is_in, cpu_event, irq;
  logic [7:0]      cpu_data;
  logic [EP_W-1:0] cpu_ep;
  logic            cpu_pop, cpu_irq_clr, cpu_reset;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0]      mq[$];
  int              m_cnt;
  bit              m_arm, m_isin, m_evt, m_ack;
  logic [EP_W-1:0] m_ep;

  setup_capture u_setup_capture (
    .clk(clk), .rst_n(rst_n), .tok_stb(tok_stb), .tok_setup(tok_setup),
    .tok_ep(tok_ep), .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_end(rx_end),
    .ack_stb(ack_stb), .cpu_data(cpu_data), .cpu_have(cpu_have),
    .cpu_is_in(cpu_is_in), .cpu_ep(cpu_ep), .cpu_event(cpu_event), .irq(irq),
    .cpu_pop(cpu_pop), .cpu_irq_clr(cpu_irq_clr), .cpu_reset(cpu_reset)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tok_stb = 0; tok_setup = 0; tok_ep = '0; rx_stb = 0; rx_byte = '0;
    rx_end = 0; cpu_pop = 0; cpu_irq_clr = 0; cpu_reset = 0;
  endtask

  // Reference model: one clock of the requirements R2..R10.
  task automatic model_step();
    bit set_evt;
    set_evt = 0;
    m_ack = 0;
    if (cpu_reset) begin
      mq.delete(); m_ep = '0; m_isin = 0; m_evt = 0; m_arm = 0; m_cnt = 0;
    end else begin
      if (cpu_pop && mq.size() > 0) void'(mq.pop_front());
      if (tok_stb) begin
        if (tok_setup) begin
          mq.delete(); m_ep = tok_ep; m_isin = 0; m_arm = 1; m_cnt = 0;
        end else m_arm = 0;
      end else if (rx_stb && m_arm) begin
        if (m_cnt == 0) m_isin = rx_byte[7];
        if (m_cnt < NB) mq.push_back(rx_byte);
        if (m_cnt < NB + 1) m_cnt++;
      end else if (rx_end && m_arm) begin
        m_ack = 1;
        if (m_cnt == NB) set_evt = 1;
        m_arm = 0;
      end
      if (set_evt) m_evt = 1;
      else if (cpu_irq_clr) m_evt = 0;
    end
  endtask

  task automatic compare_all();
    check("R3", "have", cpu_have, mq.size() != 0);
    if (mq.size() != 0) check("R3", "data", cpu_data, mq[0]);
    check("R4", "is_in", cpu_is_in, m_isin);
    check("R2", "ep", cpu_ep, m_ep);
    check("R5", "ack", ack_stb, m_ack);
    check("R6", "event", cpu_event, m_evt);
    check("R6", "irq", irq, m_evt);
  endtask

  // Inputs are set before the call (at a negedge); sample at the next negedge.
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic send_setup(input logic [EP_W-1:0] ep, input int nbytes, input bit rand_pop);
    tok_stb = 1; tok_setup = 1; tok_ep = ep; step();
    for (int i = 0; i < nbytes; i++) begin
      rx_stb = 1; rx_byte = 8'($urandom);
      if (rand_pop) cpu_pop = ($urandom_range(0, 3) == 0);
      step();
    end
    rx_end = 1; step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 1'b0;
    mq.delete(); m_cnt = 0; m_arm = 0; m_isin = 0; m_evt = 0; m_ack = 0; m_ep = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "have", cpu_have, 0);
    check("R1", "is_in", cpu_is_in, 0);
    check("R1", "event", cpu_event, 0);
    check("R1", "irq", irq, 0);
    check("R1", "ack", ack_stb, 0);
    check("R1", "ep", cpu_ep, 0);

    // R8: pop on empty queue is ignored
    cpu_pop = 1; step();
    check("R8", "have after empty pop", cpu_have, 0);

    // R6/R4: exact ten-byte request, direction bit set
    tok_stb = 1; tok_setup = 1; tok_ep = 4'd5; step();
    rx_stb = 1; rx_byte = 8'h80; step();
    check("R4", "is_in from first byte", cpu_is_in, 1);
    for (int i = 1; i < NB; i++) begin rx_stb = 1; rx_byte = 8'(i); step(); end
    rx_end = 1; step();
    check("R5", "ack after end", ack_stb, 1);
    check("R6", "irq after 10 bytes", irq, 1);
    step();
    check("R5", "ack one cycle", ack_stb, 0);
    check("R8", "data head", cpu_data, 8'h80);

    // R7: clear the interrupt
    cpu_irq_clr = 1; step();
    check("R7", "irq cleared", irq, 0);

    // R2: new SETUP flushes unread bytes
    tok_stb = 1; tok_setup = 1; tok_ep = 4'd9; step();
    check("R2", "flushed", cpu_have, 0);
    check("R2", "ep", cpu_ep, 9);

    // R7: clear collides with completion, set wins
    for (int i = 0; i < NB; i++) begin rx_stb = 1; rx_byte = 8'(i + 16); step(); end
    rx_end = 1; cpu_irq_clr = 1; step();
    check("R7", "set wins over clear", irq, 1);

    // R9: soft reset mid-capture cancels the ACK
    tok_stb = 1; tok_setup = 1; tok_ep = 4'd3; step();
    rx_stb = 1; rx_byte = 8'hC1; step();
    cpu_reset = 1; step();
    check("R9", "queue empty", cpu_have, 0);
    check("R9", "event cleared", cpu_event, 0);
    check("R9", "ep cleared", cpu_ep, 0);
    rx_end = 1; step();
    check("R9", "no ack after reset", ack_stb, 0);

    // R10: non-SETUP token cancels capture, data not stored
    send_setup(4'd2, 3, 0);
    tok_stb = 1; tok_setup = 0; tok_ep = 4'd2; step();
    tok_stb = 1; tok_setup = 1; tok_ep = 4'd2; step();
    tok_stb = 1; tok_setup = 0; step();
    rx_stb = 1; rx_byte = 8'h55; step();
    check("R10", "data ignored", cpu_have, 0);
    rx_end = 1; step();
    check("R10", "no ack", ack_stb, 0);

    // R3: long packet keeps only the first ten bytes
    send_setup(4'd1, 12, 0);
    check("R3", "long packet no event", cpu_event, 0);

    // Random mix
    for (int t = 0; t < 400; t++) begin
      int kind;
      kind = $urandom_range(0, 9);
      if (kind <= 4) send_setup(4'($urandom), $urandom_range(0, 12), 1);
      else if (kind == 5) begin
        tok_stb = 1; tok_setup = 0; tok_ep = 4'($urandom); step();
        for (int i = 0; i < $urandom_range(0, 4); i++) begin
          rx_stb = 1; rx_byte = 8'($urandom); step();
        end
        rx_end = 1; step();
      end else if (kind == 6) begin
        for (int i = 0; i < $urandom_range(1, 11); i++) begin cpu_pop = 1; step(); end
      end else if (kind == 7) begin
        cpu_irq_clr = 1; step();
      end else if (kind == 8) begin
        cpu_reset = ($urandom_range(0, 3) == 0); cpu_pop = 1; step();
      end else begin
        step();
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule